// File: doc/BRIEF.md
# Chip-Select Strobe Timing Generator

This block drives the control strobes of one external memory bank. A single-cycle transfer request starts a read or write access. The block then produces the active-low chip-select, output-enable and write/byte-enable strobes and a transfer-acknowledge pulse that marks the final bus clock of the access. The bank configuration sets the cycle length and where each strobe is placed. It has three parts: a wait-state count, a relaxed-timing bit, and a two-bit code that sets how far chip-select trails the address.

The block runs on a clock four times faster than the external bus clock. Each bus clock therefore spans four quarter slots, and a strobe edge can fall on any quarter. A free-running phase counter produces the bus clock, which the block exports. A request is accepted only on a quarter that opens a bus clock, so every access starts on a bus-clock rising edge. The configuration is captured when the access starts and holds for its whole length. Address decoding, bursts, arbitration and the data path belong to other blocks.

Top module: `cs_strobe_gen`

## Requirements
- R1: With relaxed timing off, an access lasts 2 + W bus clocks (W = wait count), i.e. 4·(2+W) quarters from the accepting edge.
- R2: With relaxed timing on, an access lasts 3 + 2·W bus clocks.
- R3: Chip-select and write-enable assert at quarter 0 of the access in normal timing, and at quarter 4 (one bus clock later) in relaxed timing.
- R4: The setup code delays chip-select and output-enable beyond their base position: code 2'b10 by one quarter, code 2'b11 by two quarters, codes 2'b00 and 2'b01 by none. Write-enable is not delayed by it.
- R5: Output-enable asserts only on reads (read_i = 1), starting at the same quarter as chip-select. It stays high on writes.
- R6: Write-enable asserts on writes. On reads it asserts only when be_mode_i = 1, because the line then serves as a byte-enable.
- R7: All asserted strobes deassert together at quarter 4·L, where L is the cycle length in bus clocks.
- R8: Transfer-acknowledge is low for exactly four quarters (one bus clock), from quarter 4·L−4 to quarter 4·L−1.
- R9: A request is accepted only on the edge at which the phase counter is 0 (the quarter that follows a rising bclk_o sample). A request at another phase, or while an access is in progress, is ignored.
- R10: While reset is asserted, all strobes and the acknowledge are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Quarter clock, four times the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transfer request |
| read_i | input | 1 | 1 = read, 0 = write |
| wait_cnt_i | input | WAIT_W | Programmed wait states |
| relax_i | input | 1 | Relaxed-timing enable |
| setup_i | input | 2 | Address-to-chip-select setup code |
| be_mode_i | input | 1 | Write-enable line acts as byte-enable (driven on reads) |
| bclk_o | output | 1 | Bus clock, high in phases 0 and 1 |
| cs_n_o | output | 1 | Chip-select, active low |
| oe_n_o | output | 1 | Output-enable, active low |
| we_n_o | output | 1 | Write/byte-enable, active low |
| ta_n_o | output | 1 | Transfer-acknowledge, active low |

## Verification
The bench runs every mix of wait count 0 to 3, relaxed bit and setup code, for both reads and writes. For each run it measures, in quarters, where each strobe falls and rises. A design that forgot to double the wait states, or to add the extra relaxed clock, would end its relaxed accesses early. If it applied the setup delay to write-enable, or treated the reserved code as a real delay, the chip-select and write-enable edges would land on the wrong quarters. The bench also sends a request while an access is running and one on a phase that does not open a bus clock; a controller that restarted or started off-phase would show a second chip-select or shifted edges.

// File: rtl/cs_strobe_pkg.sv
package cs_strobe_pkg;

  typedef enum logic [1:0] {
    SETUP_NONE = 2'b00,
    SETUP_RSVD = 2'b01,
    SETUP_QTR  = 2'b10,
    SETUP_HALF = 2'b11
  } setup_e;

  localparam int unsigned N_STROBE = 3;
  localparam int unsigned CH_CS = 0;
  localparam int unsigned CH_OE = 1;
  localparam int unsigned CH_WE = 2;

  // extra chip-select delay in quarter slots
  function automatic int unsigned setup_delay(setup_e code, int unsigned phases);
    case (code)
      SETUP_QTR:  return phases / 4;
      SETUP_HALF: return phases / 2;
      default:    return 0;
    endcase
  endfunction

endpackage

// File: rtl/cs_phase_gen.sv
module cs_phase_gen #(
  parameter int unsigned PHASES = 4,
  localparam int unsigned PH_W = $clog2(PHASES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] phase_o,
  output logic            align_o,
  output logic            bclk_o
);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_q + 1'b1;
  end

  assign phase_o = ph_q;
  assign align_o = (ph_q == '0);
  assign bclk_o  = (ph_q < PH_W'(PHASES / 2));

  AST_PHASE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_W'(PHASES - 1)) |=> align_o); // R9

endmodule

// File: rtl/cs_timing_calc.sv
module cs_timing_calc
  import cs_strobe_pkg::*;
#(
  parameter int unsigned WAIT_W = 4,
  parameter int unsigned PHASES = 4,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              relax_i,
  input  logic [WAIT_W-1:0] waits_i,
  input  setup_e            setup_i,
  output logic [CNT_W-1:0]  last_q_o,
  output logic [CNT_W-1:0]  ta_q_o,
  output logic [CNT_W-1:0]  cs_q_o,
  output logic [CNT_W-1:0]  we_q_o
);

  localparam int unsigned PH_W = $clog2(PHASES);

  logic [CNT_W-1:0] w_ext, len_bclk, len_q, base_q;

  always_comb begin
    w_ext    = CNT_W'(waits_i);
    // relaxed: each wait counts twice, plus one clock for delayed strobes
    len_bclk = relax_i ? (CNT_W'(3) + (w_ext << 1)) : (CNT_W'(2) + w_ext);
    len_q    = len_bclk << PH_W;
    base_q   = relax_i ? CNT_W'(PHASES) : '0;
    last_q_o = len_q - 1'b1;
    ta_q_o   = len_q - CNT_W'(PHASES);
    cs_q_o   = base_q + CNT_W'(setup_delay(setup_i, PHASES));
    we_q_o   = base_q;
  end

endmodule

// File: rtl/cs_cycle_ctrl.sv
module cs_cycle_ctrl
  import cs_strobe_pkg::*;
#(
  parameter int unsigned WAIT_W = 4,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              align_i,
  input  logic              read_i,
  input  logic [WAIT_W-1:0] wait_cnt_i,
  input  logic              relax_i,
  input  setup_e            setup_i,
  input  logic              be_mode_i,
  input  logic [CNT_W-1:0]  last_q_i,
  output logic              busy_o,
  output logic [CNT_W-1:0]  q_o,
  output logic              read_o,
  output logic [WAIT_W-1:0] waits_o,
  output logic              relax_o,
  output setup_e            setup_o,
  output logic              be_mode_o
);

  logic accept;
  assign accept = start_i && align_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      q_o       <= '0;
      read_o    <= 1'b0;
      waits_o   <= '0;
      relax_o   <= 1'b0;
      setup_o   <= SETUP_NONE;
      be_mode_o <= 1'b0;
    end else if (accept) begin
      busy_o    <= 1'b1;
      q_o       <= '0;
      read_o    <= read_i;
      waits_o   <= wait_cnt_i;
      relax_o   <= relax_i;
      setup_o   <= setup_i;
      be_mode_o <= be_mode_i;
    end else if (busy_o) begin
      if (q_o == last_q_i) begin
        busy_o <= 1'b0;
        q_o    <= '0;
      end else begin
        q_o <= q_o + 1'b1;
      end
    end
  end

  AST_ACCEPT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(align_i)); // R9
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && q_o != last_q_i) |=> (busy_o && q_o == $past(q_o) + 1'b1)); // R9
  AST_Q_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (q_o <= last_q_i)); // R1

endmodule

// File: rtl/cs_strobe_drv.sv
module cs_strobe_drv
  import cs_strobe_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          busy_i,
  input  logic [CNT_W-1:0]              q_i,
  input  logic [N_STROBE-1:0][CNT_W-1:0] on_q_i,
  input  logic [N_STROBE-1:0]           en_i,
  input  logic [CNT_W-1:0]              ta_q_i,
  input  logic                          read_i,
  input  logic                          be_mode_i,
  output logic [N_STROBE-1:0]           str_n_o,
  output logic                          ta_n_o
);

  for (genvar g = 0; g < N_STROBE; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) str_n_o[g] <= 1'b1;
      else         str_n_o[g] <= !(busy_i && en_i[g] && (q_i >= on_q_i[g]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ta_n_o <= 1'b1;
    else         ta_n_o <= !(busy_i && (q_i >= ta_q_i));
  end

  AST_OE_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !str_n_o[CH_OE] |-> $past(read_i)); // R5
  AST_WE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!str_n_o[CH_WE] && $past(read_i)) |-> $past(be_mode_i)); // R6
  AST_END_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(str_n_o[CH_CS]) |-> (str_n_o[CH_OE] && str_n_o[CH_WE] && ta_n_o)); // R7
  AST_TA_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ta_n_o |-> !str_n_o[CH_CS]); // R8

endmodule

// File: rtl/cs_strobe_gen.sv
module cs_strobe_gen
  import cs_strobe_pkg::*;
#(
  parameter int unsigned WAIT_W = 4,
  parameter int unsigned PHASES = 4,
  localparam int unsigned MAX_W  = (1 << WAIT_W) - 1,
  localparam int unsigned MAX_Q  = PHASES * (3 + 2 * MAX_W),
  localparam int unsigned CNT_W  = $clog2(MAX_Q + 1),
  localparam int unsigned PH_W   = $clog2(PHASES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              read_i,
  input  logic [WAIT_W-1:0] wait_cnt_i,
  input  logic              relax_i,
  input  logic [1:0]        setup_i,
  input  logic              be_mode_i,
  output logic              bclk_o,
  output logic              cs_n_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic              ta_n_o
);

  logic [PH_W-1:0]   phase;
  logic              align;
  logic              busy;
  logic [CNT_W-1:0]  q;
  logic              c_read, c_relax, c_be;
  logic [WAIT_W-1:0] c_waits;
  setup_e            c_setup;
  logic [CNT_W-1:0]  last_q, ta_q, cs_q, we_q;
  logic [N_STROBE-1:0][CNT_W-1:0] on_q;
  logic [N_STROBE-1:0] en, str_n;

  cs_phase_gen #(.PHASES(PHASES)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase),
    .align_o (align),
    .bclk_o  (bclk_o)
  );

  cs_cycle_ctrl #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .align_i    (align),
    .read_i     (read_i),
    .wait_cnt_i (wait_cnt_i),
    .relax_i    (relax_i),
    .setup_i    (setup_e'(setup_i)),
    .be_mode_i  (be_mode_i),
    .last_q_i   (last_q),
    .busy_o     (busy),
    .q_o        (q),
    .read_o     (c_read),
    .waits_o    (c_waits),
    .relax_o    (c_relax),
    .setup_o    (c_setup),
    .be_mode_o  (c_be)
  );

  cs_timing_calc #(.WAIT_W(WAIT_W), .PHASES(PHASES), .CNT_W(CNT_W)) u_calc (
    .relax_i  (c_relax),
    .waits_i  (c_waits),
    .setup_i  (c_setup),
    .last_q_o (last_q),
    .ta_q_o   (ta_q),
    .cs_q_o   (cs_q),
    .we_q_o   (we_q)
  );

  always_comb begin
    on_q[CH_CS] = cs_q;
    on_q[CH_OE] = cs_q;
    on_q[CH_WE] = we_q;
    en[CH_CS]   = 1'b1;
    en[CH_OE]   = c_read;
    en[CH_WE]   = !c_read || c_be;
  end

  cs_strobe_drv #(.CNT_W(CNT_W)) u_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy),
    .q_i       (q),
    .on_q_i    (on_q),
    .en_i      (en),
    .ta_q_i    (ta_q),
    .read_i    (c_read),
    .be_mode_i (c_be),
    .str_n_o   (str_n),
    .ta_n_o    (ta_n_o)
  );

  assign cs_n_o = str_n[CH_CS];
  assign oe_n_o = str_n[CH_OE];
  assign we_n_o = str_n[CH_WE];

  AST_IDLE_ON_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !(start_i && phase == '0)) |=> !busy); // R9

endmodule

// File: tb/tb_cs_strobe_gen.sv
module tb_cs_strobe_gen;

  localparam int WAIT_W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, read_i = 1'b0, relax_i = 1'b0, be_mode_i = 1'b0;
  logic [WAIT_W-1:0] wait_cnt_i = '0;
  logic [1:0] setup_i = 2'b00;
  logic bclk_o, cs_n_o, oe_n_o, we_n_o, ta_n_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cs_strobe_gen #(.WAIT_W(WAIT_W), .PHASES(4)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .read_i(read_i),
    .wait_cnt_i(wait_cnt_i), .relax_i(relax_i), .setup_i(setup_i),
    .be_mode_i(be_mode_i), .bclk_o(bclk_o), .cs_n_o(cs_n_o),
    .oe_n_o(oe_n_o), .we_n_o(we_n_o), .ta_n_o(ta_n_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // wait at negedge until the phase counter is 0
  task automatic align_bus();
    logic prev;
    prev = bclk_o;
    forever begin
      @(negedge clk);
      if (bclk_o && !prev) break;
      prev = bclk_o;
    end
  endtask

  // run one access; record first low / following high quarter per strobe
  task automatic run_access(input int w, input bit rlx, input int su, input bit rd,
                            input bit be);
    int lo[4], hi[4];
    logic s[4];
    int len, e, base, off;
    for (int i = 0; i < 4; i++) begin lo[i] = -1; hi[i] = -1; end
    wait_cnt_i = WAIT_W'(w); relax_i = rlx; setup_i = 2'(su);
    read_i = rd; be_mode_i = be;
    len = rlx ? 3 + 2 * w : 2 + w;
    e = 4 * len;
    align_bus();
    start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    for (int n = 1; n <= e + 6; n++) begin
      @(posedge clk); @(negedge clk);
      s[0] = cs_n_o; s[1] = oe_n_o; s[2] = we_n_o; s[3] = ta_n_o;
      for (int i = 0; i < 4; i++) begin
        if (!s[i] && lo[i] < 0) lo[i] = n - 1;
        if (s[i] && lo[i] >= 0 && hi[i] < 0) hi[i] = n - 1;
      end
    end
    base = rlx ? 4 : 0;
    off = (su == 2) ? 1 : (su == 3) ? 2 : 0;
    // R3 R4 chip-select start, R7 common end
    check(lo[0] == base + off, "R4 cs start", lo[0], base + off);
    check(hi[0] == e, rlx ? "R2 cs end" : "R1 cs end", hi[0], e);
    check(lo[1] == (rd ? base + off : -1), "R5 oe start", lo[1], rd ? base + off : -1);
    check(hi[1] == (rd ? e : -1), "R7 oe end", hi[1], rd ? e : -1);
    check(lo[2] == ((!rd || be) ? base : -1), "R6 we start", lo[2], (!rd || be) ? base : -1);
    check(hi[2] == ((!rd || be) ? e : -1), "R3 we end", hi[2], (!rd || be) ? e : -1);
    check(lo[3] == e - 4, "R8 ta start", lo[3], e - 4);
    check(hi[3] == e, "R8 ta end", hi[3], e);
  endtask

  task automatic test_reset();
    check(cs_n_o && oe_n_o && we_n_o && ta_n_o, "R10 reset strobes",
          {cs_n_o, oe_n_o, we_n_o, ta_n_o}, 4'hf);
  endtask

  task automatic test_sweep();
    for (int rd = 0; rd < 2; rd++)
      for (int rlx = 0; rlx < 2; rlx++)
        for (int w = 0; w < 4; w++)
          for (int su = 0; su < 4; su++)
            run_access(w, rlx[0], su, rd[0], 1'b0);
  endtask

  task automatic test_byte_enable();
    for (int rlx = 0; rlx < 2; rlx++)
      for (int su = 0; su < 4; su++)
        run_access(1, rlx[0], su, 1'b1, 1'b1);
  endtask

  // R9: a request during an access is ignored
  task automatic test_busy_ignore();
    int hi_at, relows;
    hi_at = -1; relows = 0;
    wait_cnt_i = 1; relax_i = 0; setup_i = 0; read_i = 1; be_mode_i = 0;
    align_bus();
    start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    for (int n = 1; n <= 28; n++) begin
      @(posedge clk); @(negedge clk);
      start_i = (n == 3);
      if (cs_n_o && hi_at < 0 && n > 1) hi_at = n - 1;
      if (!cs_n_o && hi_at >= 0) relows++;
    end
    start_i = 1'b0;
    check(hi_at == 12, "R9 busy end", hi_at, 12);
    check(relows == 0, "R9 busy no restart", relows, 0);
  endtask

  // R9: a request off the bus-clock phase is ignored
  task automatic test_misaligned();
    int lows;
    lows = 0;
    wait_cnt_i = 0; relax_i = 0; setup_i = 0; read_i = 0; be_mode_i = 0;
    align_bus();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      if (!cs_n_o || !we_n_o) lows++;
    end
    check(lows == 0, "R9 off-phase ignored", lows, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_sweep();
    test_byte_enable();
    test_busy_ignore();
    test_misaligned();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule